// File: doc/BRIEF.md
# Byte-Lane Gated 24-Bit Word Memory

This block is a synchronous storage array whose 24-bit words are split into three independent 8-bit lanes: lane 0 is bits 7:0, lane 1 is bits 15:8 and lane 2 is bits 23:16. Each lane has its own active-low select. A shared active-low write strobe and a shared active-low output enable control the whole array. A lane takes part in an access only while its select is low. Lanes whose select is high are left untouched, so a single access can read or update any subset of the three bytes.

Writes are captured on the rising clock edge. Reads are registered: the read data and a per-lane drive flag appear one cycle after the request. The drive flag marks which lanes a bidirectional pad would drive. A lane whose flag is low stands for high impedance, and its data bits read zero. A registered standby flag reports that no lane was selected. The word index is taken from the low bits of a 19-bit address, so the depth can be cut down for simulation.

Top module: `tri_lane_sram`

## Requirements
- R1: On a rising edge where write strobe is low and a lane's select is low, that lane's 8 bits of write data (lane 0 = bits 7:0, lane 1 = 15:8, lane 2 = 23:16) are stored at the addressed word.
- R2: During a write, a lane whose select is high keeps its stored byte unchanged.
- R3: When a lane's select is low, write strobe is high and output enable is low at a rising edge, that lane's drive flag is 1 after that edge and its read data holds the stored byte.
- R4: While write strobe is low, output enable has no effect and no lane's drive flag is set after that edge.
- R5: When all three selects are high at an edge, standby is 1 and every drive flag is 0 after that edge; otherwise standby is 0.
- R6: With all lanes selected and both write strobe and output enable high, standby is 0 and every drive flag is 0.
- R7: A lane whose drive flag is 0 presents all-zero read data.
- R8: Only the low log2(DEPTH) address bits select the word; two addresses that differ only in the upper bits reach the same word.
- R9: While reset is low and on the first cycle after it, drive flags and read data are 0 and standby is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (19) | Word address, low bits used |
| lane_sel_n | input | LANES (3) | Active-low per-lane selects |
| wr_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| wdata | input | LANES*LANE_W (24) | Write data |
| rdata | output | LANES*LANE_W (24) | Registered read data, zero on undriven lanes |
| lane_drive | output | LANES (3) | Registered per-lane drive flag (0 = high impedance) |
| standby | output | 1 | Registered flag: no lane was selected |

## Verification
First the whole array is filled with writes that select all lanes. Then random cycles mix every select pattern with random write strobe, output enable and full-width addresses. These cycles show whether lane masking applies to both reads and writes, and whether output enable is ignored during writes. Directed cycles cover cases that random stimulus does not single out. Partial-lane writes are read back with all lanes selected, which shows that unselected bytes are kept. Reads through an alias address that differs only in upper bits test address truncation. The all-deselected case and the "selected but outputs disabled" case are each driven on purpose, because they share zero drive flags and differ only in the standby flag.

// File: rtl/tls_pkg.sv
// Package: shared constants and the access-kind encoding for the lane memory.
// Assumes three 8-bit lanes as the default word layout.
package tls_pkg;
    localparam int DEF_LANES  = 3;
    localparam int DEF_LANE_W = 8;
    localparam int DEF_ADDR_W = 19;

    typedef enum logic [1:0] {
        ACC_OFF   = 2'd0,
        ACC_IDLE  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_READ  = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/tls_lane_ctrl.sv
// Lane control decode: turns the active-low controls into per-lane write and read
// masks, plus an all-deselected flag. Purely combinational.
// Assumes that write strobe low overrides output enable.
module tls_lane_ctrl
    import tls_pkg::*;
#(
    parameter int LANES = DEF_LANES
) (
    input  logic [LANES-1:0] sel_n,
    input  logic             wr_n,
    input  logic             oe_n,
    output logic [LANES-1:0] wr_mask,
    output logic [LANES-1:0] rd_mask,
    output logic             all_off,
    output acc_kind_e        kind
);
    // Classify the access, then gate it by the selected lanes.
    always_comb begin
        all_off = &sel_n;
        if (all_off)       kind = ACC_OFF;
        else if (!wr_n)    kind = ACC_WRITE;
        else if (!oe_n)    kind = ACC_READ;
        else               kind = ACC_IDLE;
        wr_mask = (kind == ACC_WRITE) ? ~sel_n : '0;
        rd_mask = (kind == ACC_READ)  ? ~sel_n : '0;
    end
endmodule

// File: rtl/tls_lane_bank.sv
// One byte lane of storage: DEPTH entries of LANE_W bits, a synchronous write
// and a registered read whose data reads zero unless the lane is driven.
// Assumes that read and write are never requested together (decode guarantees this).
module tls_lane_bank #(
    parameter int DEPTH  = 1024,
    parameter int LANE_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata,
    output logic              drive
);
    logic [LANE_W-1:0] store [DEPTH];

    // Storage update: write the byte when this lane is written.
    always_ff @(posedge clk) begin
        if (wr_en) store[idx] <= wdata;
    end

    // Read register: capture the byte and the drive flag, zero when not driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            drive <= 1'b0;
        end else begin
            drive <= rd_en;
            rdata <= rd_en ? store[idx] : '0;
        end
    end
endmodule

// File: rtl/tri_lane_sram.sv
// Top: a byte-lane gated word memory. Each lane has its own active-low select.
// Write strobe and output enable are shared. Read data, lane drive flags and
// standby are all registered.
// Assumes DEPTH is a power of two no larger than 2**ADDR_W.
module tri_lane_sram
    import tls_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W,
    localparam int WORD_W = LANES * LANE_W,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              wr_n,
    input  logic              out_en_n,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  lane_drive,
    output logic              standby
);
    logic [LANES-1:0] wr_mask;
    logic [LANES-1:0] rd_mask;
    logic             all_off;
    acc_kind_e        kind;
    logic [IDX_W-1:0] idx;

    assign idx = addr[IDX_W-1:0];

    tls_lane_ctrl #(.LANES(LANES)) u_ctrl (
        .sel_n   (lane_sel_n),
        .wr_n    (wr_n),
        .oe_n    (out_en_n),
        .wr_mask (wr_mask),
        .rd_mask (rd_mask),
        .all_off (all_off),
        .kind    (kind)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tls_lane_bank #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .idx   (idx),
            .wr_en (wr_mask[g]),
            .rd_en (rd_mask[g]),
            .wdata (wdata[g*LANE_W +: LANE_W]),
            .rdata (rdata[g*LANE_W +: LANE_W]),
            .drive (lane_drive[g])
        );
    end

    // Standby register: set when the access kind says no lane is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) standby <= 1'b1;
        else        standby <= (kind == ACC_OFF);
    end
endmodule

// File: rtl/tls_checker.sv
// Checker: temporal properties of the lane memory, bound to the top module.
// Assumes the reset is synchronous and active low.
module tls_checker #(
    parameter int ADDR_W = 19,
    parameter int LANES  = 3,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES-1:0]        lane_sel_n,
    input logic                    wr_n,
    input logic                    out_en_n,
    input logic [LANES*LANE_W-1:0] rdata,
    input logic [LANES-1:0]        lane_drive,
    input logic                    standby
);
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R3: a lane drives only after a selected read with output enabled
        assert_drive_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            lane_drive[g] |-> $past(!lane_sel_n[g] && wr_n && !out_en_n));
        // R7: an undriven lane shows zero data
        assert_quiet_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_drive[g] |-> (rdata[g*LANE_W +: LANE_W] == '0));
    end

    // R4: a write cycle leaves every lane undriven
    assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (lane_drive == '0));
    // R5: standby follows the all-deselected condition and silences the lanes
    assert_standby_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        &lane_sel_n |=> (standby && lane_drive == '0));
    assert_standby_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> ($past(&lane_sel_n) || $past(!rst_n)));
    // R6: selected but both strobes high gives no drive and no standby
    assert_idle_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_n == '0 && wr_n && out_en_n) |=> (!standby && lane_drive == '0));
endmodule

bind tri_lane_sram tls_checker #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_sel_n (lane_sel_n),
    .wr_n       (wr_n),
    .out_en_n   (out_en_n),
    .rdata      (rdata),
    .lane_drive (lane_drive),
    .standby    (standby)
);

// File: tb/tri_lane_sram_test.sv
// Bench: fills the array, then runs directed corners and seeded random cycles
// against a bench-side model of the memory.
module tri_lane_sram_test;
    localparam int DEPTH  = 1024;
    localparam int ADDR_W = 19;
    localparam int IDX_W  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] addr = '0;
    logic [2:0]  lane_sel_n = 3'b111;
    logic        wr_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic [23:0] wdata = '0;
    logic [23:0] rdata;
    logic [2:0]  lane_drive;
    logic        standby;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [23:0] model [DEPTH];

    always #4 clk = ~clk;

    tri_lane_sram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .lane_sel_n(lane_sel_n),
        .wr_n(wr_n), .out_en_n(out_en_n), .wdata(wdata),
        .rdata(rdata), .lane_drive(lane_drive), .standby(standby)
    );

    function automatic logic [2:0] exp_drive(logic [2:0] s, logic w, logic o);
        return (w && !o) ? ~s : 3'b000;
    endfunction

    function automatic logic [23:0] exp_rdata(logic [2:0] d, logic [23:0] word);
        logic [23:0] r = '0;
        for (int i = 0; i < 3; i++) if (d[i]) r[i*8 +: 8] = word[i*8 +: 8];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, clock, check at the next negedge.
    task automatic access(logic [18:0] a, logic [2:0] s, logic w, logic o,
                          logic [23:0] d, string req);
        logic [2:0]  ed;
        logic [23:0] er;
        logic [IDX_W-1:0] ix;
        addr = a; lane_sel_n = s; wr_n = w; out_en_n = o; wdata = d;
        ix = a[IDX_W-1:0];
        ed = exp_drive(s, w, o);
        er = exp_rdata(ed, model[ix]);
        if (!w) for (int i = 0; i < 3; i++)
            if (!s[i]) model[ix][i*8 +: 8] = d[i*8 +: 8];
        @(negedge clk);
        check({req, " drive"}, {29'd0, lane_drive}, {29'd0, ed});
        check({req, " data"}, {8'd0, rdata}, {8'd0, er});
        check({req, " standby"}, {31'd0, standby}, {31'd0, &s});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5A17);
        // R9: reset state
        repeat (2) @(negedge clk);
        check("R9 drive", {29'd0, lane_drive}, 0);
        check("R9 data", {8'd0, rdata}, 0);
        check("R9 standby", {31'd0, standby}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 post drive", {29'd0, lane_drive}, 0);
        check("R9 post standby", {31'd0, standby}, 1);
        // R1: fill every word with all lanes selected
        for (int i = 0; i < DEPTH; i++)
            access(19'(i), 3'b000, 1'b0, 1'b1, 24'(i * 32'h010203 + 32'h5A), "R1 fill");
        // R4: write with output enable low drives nothing
        access(19'd5, 3'b000, 1'b0, 1'b0, 24'hA1B2C3, "R4 write oe low");
        access(19'd5, 3'b000, 1'b1, 1'b0, 24'h0, "R1 readback");
        // R2: write lane 1 only, others keep bytes
        access(19'd5, 3'b101, 1'b0, 1'b1, 24'hFFEEDD, "R2 partial write");
        access(19'd5, 3'b000, 1'b1, 1'b0, 24'h0, "R2 readback");
        // R3: single-lane reads
        access(19'd5, 3'b110, 1'b1, 1'b0, 24'h0, "R3 lane0 read");
        access(19'd5, 3'b011, 1'b1, 1'b0, 24'h0, "R3 lane2 read");
        // R5: all deselected with read strobes
        access(19'd5, 3'b111, 1'b1, 1'b0, 24'h0, "R5 standby");
        // R6: all selected, outputs disabled
        access(19'd5, 3'b000, 1'b1, 1'b1, 24'h0, "R6 idle selected");
        // R8: alias through upper address bits
        access(19'd7 | 19'(DEPTH), 3'b000, 1'b0, 1'b1, 24'h123456, "R8 alias write");
        access(19'd7 | 19'(DEPTH * 37), 3'b000, 1'b1, 1'b0, 24'h0, "R8 alias read");
        access(19'd7, 3'b000, 1'b1, 1'b0, 24'h0, "R8 base read");
        // R7 with R3: random mix of all control patterns
        for (int n = 0; n < 3000; n++) begin
            access(19'($urandom), 3'($urandom), ($urandom % 3) != 0, 1'($urandom),
                   24'($urandom), "R7 random");
        end
        finish_run();
    end
endmodule